// File: doc/BRIEF.md
# Parallel Converter Bus Interface

This block connects a register-programmed controller to one external parallel analogue-to-digital converter and one external parallel digital-to-analogue converter. Both converters sit on a single set of pins: an 8-bit address lane and a 16-bit data lane pair. A single sequencer owns the pins, so only one converter access is in flight at any time.

A conversion can be started by a register write, by an internal trigger pulse from elsewhere on the chip, or by the rising edge of an asynchronous trigger pin. The sequencer asserts the converter select and drives the conversion address. After a programmable setup time it pulses the read/convert strobe for a programmable width, and then waits for the converter's ready input. On ready it captures the data pins, raises a level interrupt and drops busy. If ready never comes, a timeout ends the access and flags an error instead.

A write to the DAC register latches a data word and an address. These are driven onto the pins, and a write strobe follows with the same setup and width timing. Any 8-bit pin lane that the lane enables and the configured data widths leave unused is handed to a general-purpose I/O function with its own direction and output registers. This gives 0, 8, 16 or 24 GPIO channels.

Top module: `cnv_bus_if`

## Requirements
- R1: After reset all three strobes (`adc_cs_n`, `adc_rc_n`, `dac_wr_n`) are high, every pin output enable is 0, `irq` is 0 and the status register (offset 4) reads 0.
- R2: Writing offset 2 with bit 8 set stores bits 7:0 as the conversion address and starts a conversion. `adc_cs_n` stays low with `adc_rc_n` high for SETUP+1 cycles, then `adc_rc_n` is low for WIDTH+1 cycles. SETUP is timing register (offset 1) bits 7:0 and WIDTH is bits 15:8. When control bit 2 is set, the address drives `pa_o` with `pa_oe` all ones for as long as `adc_cs_n` is low.
- R3: After the strobe, the first cycle with `adc_rdy` high ends the conversion and latches the data pins into the result register (offset 3). In 8-bit mode (control bit 0 clear) only `pd_i[7:0]` is latched, zero-extended; in 16-bit mode the full `pd_i` is latched. Status bit 0 (busy) is 1 from the accepted start until that latch.
- R4: `irq` (also status bit 1) rises when a result is latched and stays high until the result register is read.
- R5: If `adc_rdy` stays low for TMO+1 waiting cycles, where TMO is timing bits 31:16, the access ends with no latch and no interrupt. Status bit 2 (error) is set. Writing 1 to status bit 2 clears it.
- R6: With control bit 5 set, a rising edge on `ext_trig`, passed through a two-flop synchroniser, starts one conversion. A level held high starts no further conversion.
- R7: With control bit 4 set, a one-cycle pulse on `int_trig` starts a conversion. With the bit clear, the pulse has no effect.
- R8: While a conversion is busy, register starts, internal and external triggers are ignored, and a write to offset 2 leaves the stored address unchanged.
- R9: A write to offset 5 latches data from bits 15:0 and address from bits 23:16. The address is driven for SETUP+1 cycles, then `dac_wr_n` is low for WIDTH+1 cycles with the data held. With control bit 1 (DAC 16-bit) clear, only `pd_o[7:0]` is driven; with it set, all 16 bits are driven.
- R10: A DAC request and a conversion request accepted in the same cycle run one after the other, the conversion first. `adc_cs_n` and `dac_wr_n` are never low together.
- R11: GPIO channels 7:0 map to the address lane, 15:8 to the low data lane and 23:16 to the high data lane. A lane is GPIO when the converters do not own it. The address lane is owned when control bit 2 is set. The low data lane is owned when control bit 3 is set. The high data lane is owned when bit 3 is set and bit 0 or bit 1 is set. On a GPIO lane, the output follows offset 7, and the enable follows offset 6, where 1 means output.
- R12: Reading offset 8 returns `{pd_i, pa_i}` as seen on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| int_trig | input | 1 | On-chip trigger pulse |
| ext_trig | input | 1 | Asynchronous trigger pin |
| adc_rdy | input | 1 | Converter ready, active high |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rc_n | output | 1 | Read/convert strobe, active low |
| dac_wr_n | output | 1 | DAC write strobe, active low |
| pa_o | output | 8 | Address lane output value |
| pa_oe | output | 8 | Address lane output enable |
| pa_i | input | 8 | Address lane pin input |
| pd_o | output | 16 | Data lanes output value |
| pd_oe | output | 16 | Data lanes output enable |
| pd_i | input | 16 | Data lanes pin input |
| irq | output | 1 | Conversion-complete interrupt, level |

## Verification
The conversion path is swept over every setup and strobe width from 0 to 3. Each setting uses a different ready delay and alternates the data width, so that an off-by-one in either timing phase, a wrong wait count and wrong zero-extension each show up as their own mismatch. Starts are also applied in other ways: from each trigger source, while busy, with the enable bits clear, and as a DAC write and a conversion request in the same cycle. These patterns tell a lost start apart from a doubled one, and show whether the arbitration order is right. Lane ownership is stepped through the control combinations that leave 24, 16, 8 and 0 GPIO channels.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_STRB  = 2'd2,
    SQ_WAIT  = 2'd3
  } sq_state_t;

  localparam logic [3:0] RA_CTRL = 4'd0;
  localparam logic [3:0] RA_TIME = 4'd1;
  localparam logic [3:0] RA_CMD  = 4'd2;
  localparam logic [3:0] RA_RES  = 4'd3;
  localparam logic [3:0] RA_STAT = 4'd4;
  localparam logic [3:0] RA_DAC  = 4'd5;
  localparam logic [3:0] RA_GDIR = 4'd6;
  localparam logic [3:0] RA_GOUT = 4'd7;
  localparam logic [3:0] RA_GIN  = 4'd8;

  localparam int CB_ADC16 = 0;
  localparam int CB_DAC16 = 1;
  localparam int CB_ALANE = 2;
  localparam int CB_DLANE = 3;
  localparam int CB_INTEN = 4;
  localparam int CB_EXTEN = 5;
  localparam int CTRL_W   = 6;
endpackage

// File: rtl/cnv_trig_sync.sv
module cnv_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] sh_q;
  logic [2:0] sh_d;

  always_comb begin
    sh_d = {sh_q[1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 3'b000;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[1] & ~sh_q[2];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R6
endmodule

// File: rtl/cnv_seq.sv
module cnv_seq #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_start_i,
  input  logic             dac_start_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             rdy_i,
  output logic             adc_sel_o,
  output logic             adc_strb_o,
  output logic             dac_strb_o,
  output logic             dac_own_o,
  output logic             active_o,
  output logic             done_o,
  output logic             tmo_o,
  output logic             adc_busy_o,
  output logic             dac_busy_o
);
  import cnv_pkg::*;
  localparam int CW = (TMO_W > CNT_W) ? TMO_W : CNT_W;

  sq_state_t      st_q, st_d;
  logic           own_dac_q, own_dac_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           apend_q, apend_d;
  logic           dpend_q, dpend_d;

  always_comb begin
    st_d      = st_q;
    own_dac_d = own_dac_q;
    cnt_d     = cnt_q;
    apend_d   = apend_q | adc_start_i;
    dpend_d   = dpend_q | dac_start_i;
    done_o    = 1'b0;
    tmo_o     = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (apend_q) begin
          st_d      = SQ_SETUP;
          own_dac_d = 1'b0;
          apend_d   = adc_start_i;
          cnt_d     = '0;
        end else if (dpend_q) begin
          st_d      = SQ_SETUP;
          own_dac_d = 1'b1;
          dpend_d   = dac_start_i;
          cnt_d     = '0;
        end
      end
      SQ_SETUP: begin
        if (cnt_q == CW'(setup_i)) begin
          st_d  = SQ_STRB;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_STRB: begin
        if (cnt_q == CW'(width_i)) begin
          st_d  = own_dac_q ? SQ_IDLE : SQ_WAIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_WAIT: begin
        if (rdy_i) begin
          st_d   = SQ_IDLE;
          done_o = 1'b1;
        end else if (cnt_q == CW'(tmo_i)) begin
          st_d  = SQ_IDLE;
          tmo_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      own_dac_q <= 1'b0;
      cnt_q     <= '0;
      apend_q   <= 1'b0;
      dpend_q   <= 1'b0;
    end else begin
      st_q      <= st_d;
      own_dac_q <= own_dac_d;
      cnt_q     <= cnt_d;
      apend_q   <= apend_d;
      dpend_q   <= dpend_d;
    end
  end

  assign active_o   = (st_q != SQ_IDLE);
  assign adc_sel_o  = active_o & ~own_dac_q;
  assign dac_own_o  = active_o & own_dac_q;
  assign adc_strb_o = (st_q == SQ_STRB) & ~own_dac_q;
  assign dac_strb_o = (st_q == SQ_STRB) & own_dac_q;
  assign adc_busy_o = apend_q | adc_sel_o;
  assign dac_busy_o = dpend_q | dac_own_o;

  AST_RC_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strb_o |-> adc_sel_o); // R2
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_sel_o && dac_strb_o)); // R10
  AST_TMO_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> !done_o); // R5
  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || tmo_o) |=> !adc_sel_o); // R3
endmodule

// File: rtl/cnv_lane_mux.sv
module cnv_lane_mux #(
  parameter int LANE_W = 8,
  parameter int NLANES = 3
) (
  input  logic [NLANES-1:0]        own_i,
  input  logic [NLANES-1:0]        cnv_oe_i,
  input  logic [NLANES*LANE_W-1:0] cnv_val_i,
  input  logic [NLANES*LANE_W-1:0] gp_dir_i,
  input  logic [NLANES*LANE_W-1:0] gp_out_i,
  output logic [NLANES*LANE_W-1:0] pin_o,
  output logic [NLANES*LANE_W-1:0] pin_oe
);
  for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
    assign pin_o[ln*LANE_W +: LANE_W]  = own_i[ln] ? cnv_val_i[ln*LANE_W +: LANE_W]
                                                   : gp_out_i[ln*LANE_W +: LANE_W];
    assign pin_oe[ln*LANE_W +: LANE_W] = own_i[ln] ? {LANE_W{cnv_oe_i[ln]}}
                                                   : gp_dir_i[ln*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/cnv_bus_if.sv
module cnv_bus_if #(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 8,
  parameter int TMO_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [3:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic                int_trig,
  input  logic                ext_trig,
  input  logic                adc_rdy,
  output logic                adc_cs_n,
  output logic                adc_rc_n,
  output logic                dac_wr_n,
  output logic [LANE_W-1:0]   pa_o,
  output logic [LANE_W-1:0]   pa_oe,
  input  logic [LANE_W-1:0]   pa_i,
  output logic [2*LANE_W-1:0] pd_o,
  output logic [2*LANE_W-1:0] pd_oe,
  input  logic [2*LANE_W-1:0] pd_i,
  output logic                irq
);
  import cnv_pkg::*;
  localparam int NL   = 3;
  localparam int GP_W = NL * LANE_W;
  localparam int DW   = 2 * LANE_W;
  localparam int TW   = 2 * CNT_W + TMO_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [TW-1:0]     time_q, time_d;
  logic [LANE_W-1:0] aaddr_q, aaddr_d;
  logic [DW-1:0]     res_q, res_d;
  logic              irq_q, irq_d;
  logic              err_q, err_d;
  logic [DW-1:0]     ddata_q, ddata_d;
  logic [LANE_W-1:0] daddr_q, daddr_d;
  logic [GP_W-1:0]   gdir_q, gdir_d;
  logic [GP_W-1:0]   gout_q, gout_d;

  logic ext_rise, adc_go, dac_go, cmd_wr, res_rd;
  logic adc_sel, adc_strb, dac_strb, dac_own, active, done, tmo, adc_busy, dac_busy;
  logic [NL-1:0]     own, cnv_oe;
  logic [GP_W-1:0]   cnv_val, pin_o, pin_oe;
  logic [DW-1:0]     cap;

  cnv_trig_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_trig),
    .rise_o (ext_rise)
  );

  cnv_seq #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_start_i(adc_go),
    .dac_start_i(dac_go),
    .setup_i    (time_q[CNT_W-1:0]),
    .width_i    (time_q[2*CNT_W-1:CNT_W]),
    .tmo_i      (time_q[TW-1:2*CNT_W]),
    .rdy_i      (adc_rdy),
    .adc_sel_o  (adc_sel),
    .adc_strb_o (adc_strb),
    .dac_strb_o (dac_strb),
    .dac_own_o  (dac_own),
    .active_o   (active),
    .done_o     (done),
    .tmo_o      (tmo),
    .adc_busy_o (adc_busy),
    .dac_busy_o (dac_busy)
  );

  assign cmd_wr = reg_wr && (reg_addr == RA_CMD);
  assign res_rd = reg_rd && (reg_addr == RA_RES);
  assign adc_go = !adc_busy && ((cmd_wr && reg_wdata[LANE_W]) ||
                                (int_trig && ctrl_q[CB_INTEN]) ||
                                (ext_rise && ctrl_q[CB_EXTEN]));
  assign dac_go = reg_wr && (reg_addr == RA_DAC) && !dac_busy;
  assign cap    = ctrl_q[CB_ADC16] ? pd_i : {{LANE_W{1'b0}}, pd_i[LANE_W-1:0]};

  always_comb begin
    ctrl_d  = ctrl_q;
    time_d  = time_q;
    aaddr_d = aaddr_q;
    res_d   = res_q;
    ddata_d = ddata_q;
    daddr_d = daddr_q;
    gdir_d  = gdir_q;
    gout_d  = gout_q;
    err_d   = err_q;
    irq_d   = irq_q;
    if (reg_wr && reg_addr == RA_CTRL) ctrl_d = reg_wdata[CTRL_W-1:0];
    if (reg_wr && reg_addr == RA_TIME) time_d = reg_wdata[TW-1:0];
    if (reg_wr && reg_addr == RA_GDIR) gdir_d = reg_wdata[GP_W-1:0];
    if (reg_wr && reg_addr == RA_GOUT) gout_d = reg_wdata[GP_W-1:0];
    if (cmd_wr && !adc_busy)           aaddr_d = reg_wdata[LANE_W-1:0];
    if (dac_go) begin
      ddata_d = reg_wdata[DW-1:0];
      daddr_d = reg_wdata[DW +: LANE_W];
    end
    if (done) res_d = cap;
    if (done)        irq_d = 1'b1;
    else if (res_rd) irq_d = 1'b0;
    if (tmo) err_d = 1'b1;
    else if (reg_wr && reg_addr == RA_STAT && reg_wdata[2]) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      time_q  <= '0;
      aaddr_q <= '0;
      res_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
      ddata_q <= '0;
      daddr_q <= '0;
      gdir_q  <= '0;
      gout_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      time_q  <= time_d;
      aaddr_q <= aaddr_d;
      res_q   <= res_d;
      irq_q   <= irq_d;
      err_q   <= err_d;
      ddata_q <= ddata_d;
      daddr_q <= daddr_d;
      gdir_q  <= gdir_d;
      gout_q  <= gout_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CTRL: reg_rdata[CTRL_W-1:0] = ctrl_q;
      RA_TIME: reg_rdata[TW-1:0]     = time_q;
      RA_CMD:  reg_rdata[LANE_W-1:0] = aaddr_q;
      RA_RES:  reg_rdata[DW-1:0]     = res_q;
      RA_STAT: reg_rdata[3:0]        = {dac_busy, err_q, irq_q, adc_busy};
      RA_DAC:  reg_rdata[DW+LANE_W-1:0] = {daddr_q, ddata_q};
      RA_GDIR: reg_rdata[GP_W-1:0]   = gdir_q;
      RA_GOUT: reg_rdata[GP_W-1:0]   = gout_q;
      RA_GIN:  reg_rdata[GP_W-1:0]   = {pd_i, pa_i};
      default: reg_rdata = '0;
    endcase
  end

  assign own[0]  = ctrl_q[CB_ALANE];
  assign own[1]  = ctrl_q[CB_DLANE];
  assign own[2]  = ctrl_q[CB_DLANE] & (ctrl_q[CB_ADC16] | ctrl_q[CB_DAC16]);
  assign cnv_oe  = {dac_own & ctrl_q[CB_DAC16], dac_own, active};
  assign cnv_val = {ddata_q, (dac_own ? daddr_q : aaddr_q)};

  cnv_lane_mux #(.LANE_W(LANE_W), .NLANES(NL)) u_mux (
    .own_i    (own),
    .cnv_oe_i (cnv_oe),
    .cnv_val_i(cnv_val),
    .gp_dir_i (gdir_q),
    .gp_out_i (gout_q),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe)
  );

  assign pa_o     = pin_o[LANE_W-1:0];
  assign pa_oe    = pin_oe[LANE_W-1:0];
  assign pd_o     = pin_o[GP_W-1:LANE_W];
  assign pd_oe    = pin_oe[GP_W-1:LANE_W];
  assign adc_cs_n = ~adc_sel;
  assign adc_rc_n = ~adc_strb;
  assign dac_wr_n = ~dac_strb;
  assign irq      = irq_q;

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !res_rd) |=> irq_q); // R4
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    adc_go |=> adc_busy); // R3
  AST_DAC_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_strb && $past(dac_strb)) |-> $stable(ddata_q)); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel && $past(adc_sel)) |-> $stable(aaddr_q)); // R8
endmodule

// File: tb/cnv_bus_if_tb.sv
module cnv_bus_if_tb_top;
  import cnv_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        int_trig, ext_trig, adc_rdy;
  logic        adc_cs_n, adc_rc_n, dac_wr_n;
  logic [7:0]  pa_o, pa_oe, pa_i;
  logic [15:0] pd_o, pd_oe, pd_i;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cnv_bus_if dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_trig(int_trig), .ext_trig(ext_trig), .adc_rdy(adc_rdy),
    .adc_cs_n(adc_cs_n), .adc_rc_n(adc_rc_n), .dac_wr_n(dac_wr_n),
    .pa_o(pa_o), .pa_oe(pa_oe), .pa_i(pa_i),
    .pd_o(pd_o), .pd_oe(pd_oe), .pd_i(pd_i), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_w(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = RA_STAT;
  endtask

  task automatic reg_r(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = RA_STAT;
  endtask

  task automatic pulse_int();
    @(negedge clk); int_trig = 1'b1;
    @(negedge clk); int_trig = 1'b0;
  endtask

  task automatic cs_quiet(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!adc_cs_n) lows++;
    end
  endtask

  task automatic adc_obs(input int rdy_after, input logic [7:0] exp_a,
                         output int n_set, output int n_strb, output int n_wait);
    int guard;
    int bad;
    bit first;
    n_set = 0; n_strb = 0; n_wait = 0; guard = 0; bad = 0; first = 1;
    while (adc_cs_n && guard < 40) begin @(negedge clk); guard++; end
    while (!adc_cs_n && guard < 400) begin
      #1;
      if (first) chk("R3 busy during conversion", {31'b0, reg_rdata[0]}, 32'd1);
      first = 0;
      if (pa_oe !== 8'hFF || pa_o !== exp_a) bad++;
      if (adc_rc_n && n_strb == 0) n_set++;
      else if (!adc_rc_n) n_strb++;
      else begin
        if (n_wait == rdy_after) adc_rdy = 1'b1;
        n_wait++;
      end
      @(negedge clk); guard++;
    end
    adc_rdy = 1'b0;
    chk("R2 address driven while selected", 32'(bad), 32'd0);
  endtask

  task automatic dac_obs(input logic [15:0] exp_oe, input logic [15:0] exp_d, input logic [7:0] exp_a,
                         output int n_set, output int n_strb, output int bad);
    int guard;
    n_set = 0; n_strb = 0; bad = 0; guard = 0;
    while (pa_oe !== 8'hFF && guard < 40) begin @(negedge clk); guard++; end
    while (pa_oe === 8'hFF && guard < 200) begin
      #1;
      if (dac_wr_n) begin
        if (n_strb == 0) n_set++;
      end else begin
        n_strb++;
        if (pd_oe !== exp_oe || (pd_o & exp_oe) !== (exp_d & exp_oe) || pa_o !== exp_a) bad++;
      end
      @(negedge clk); guard++;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int ns, nst, nw, lows, bad, fcs, fwr, ov;
    logic [31:0] rd;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = RA_STAT; reg_wdata = 0;
    int_trig = 0; ext_trig = 0; adc_rdy = 0; pa_i = 8'h00; pd_i = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 strobes idle", {29'b0, adc_cs_n, adc_rc_n, dac_wr_n}, 32'd7);
    chk("R1 pin enables", {8'b0, pd_oe, pa_oe}, 32'd0);
    chk("R1 irq low", {31'b0, irq}, 32'd0);
    chk("R1 status zero", reg_rdata, 32'd0);

    // R2 R3 R4 sweep of timing, widths and ready delay
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        int ra;
        logic w16;
        logic [15:0] val;
        logic [7:0] a;
        ra  = (s + w) % 3;
        w16 = 1'((s + w) % 2);
        val = 16'hC3A0 | 16'(s * 4 + w);
        a   = 8'h40 + 8'(s * 4 + w);
        reg_w(RA_CTRL, 32'h0C | {31'b0, w16});
        reg_w(RA_TIME, {16'd100, 8'(w), 8'(s)});
        pd_i = val;
        reg_w(RA_CMD, 32'h100 | {24'b0, a});
        adc_obs(ra, a, ns, nst, nw);
        chk("R2 setup cycles", 32'(ns), 32'(s + 1));
        chk("R2 strobe cycles", 32'(nst), 32'(w + 1));
        chk("R3 ready wait cycles", 32'(nw), 32'(ra + 1));
        #1;
        chk("R4 irq after completion", {31'b0, irq}, 32'd1);
        chk("R3 busy clear after latch", {31'b0, reg_rdata[0]}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R4 irq held", {31'b0, irq}, 32'd1);
        reg_r(RA_RES, rd);
        chk("R3 result value", rd, w16 ? {16'b0, val} : {24'b0, val[7:0]});
        #1;
        chk("R4 irq cleared by read", {31'b0, irq}, 32'd0);
      end
    end

    // R5 timeout
    reg_w(RA_CTRL, 32'h0C);
    reg_w(RA_TIME, {16'd3, 8'd0, 8'd0});
    reg_w(RA_CMD, 32'h155);
    adc_obs(-1, 8'h55, ns, nst, nw);
    chk("R5 wait cycles before timeout", 32'(nw), 32'd4);
    #1;
    chk("R5 error flag set", {31'b0, reg_rdata[2]}, 32'd1);
    chk("R5 no irq on timeout", {31'b0, irq}, 32'd0);
    reg_w(RA_STAT, 32'h4);
    #1;
    chk("R5 error flag cleared", {31'b0, reg_rdata[2]}, 32'd0);

    // R7 internal trigger disabled then enabled
    reg_w(RA_TIME, {16'd40, 8'd0, 8'd1});
    pulse_int();
    cs_quiet(10, lows);
    chk("R7 disabled trigger ignored", 32'(lows), 32'd0);
    reg_w(RA_CTRL, 32'h1C);
    pd_i = 16'h0077;
    pulse_int();
    adc_obs(0, 8'h55, ns, nst, nw);
    chk("R7 trigger conversion strobe", 32'(nst), 32'd1);
    chk("R7 trigger conversion irq", {31'b0, irq}, 32'd1);
    reg_r(RA_RES, rd);
    chk("R7 trigger result", rd, 32'h77);

    // R8 starts while busy
    reg_w(RA_TIME, {16'd40, 8'd0, 8'd8});
    reg_w(RA_CMD, 32'h111);
    reg_w(RA_CMD, 32'h122);
    pulse_int();
    adc_obs(2, 8'h11, ns, nst, nw);
    reg_r(RA_RES, rd);
    cs_quiet(12, lows);
    chk("R8 no extra conversion", 32'(lows), 32'd0);
    reg_r(RA_CMD, rd);
    chk("R8 address kept", rd, 32'h11);

    // R6 external trigger
    reg_w(RA_CTRL, 32'h2C);
    reg_w(RA_TIME, {16'd40, 8'd1, 8'd0});
    pd_i = 16'h00E1;
    @(negedge clk); ext_trig = 1'b1;
    adc_obs(1, 8'h11, ns, nst, nw);
    chk("R6 external start strobe", 32'(nst), 32'd2);
    chk("R6 external start irq", {31'b0, irq}, 32'd1);
    reg_r(RA_RES, rd);
    chk("R6 external result", rd, 32'hE1);
    cs_quiet(15, lows);
    chk("R6 held level single start", 32'(lows), 32'd0);
    ext_trig = 1'b0;

    // R9 DAC 8-bit then 16-bit
    reg_w(RA_CTRL, 32'h0C);
    reg_w(RA_GDIR, 32'h0);
    reg_w(RA_TIME, {16'd40, 8'd1, 8'd2});
    reg_w(RA_DAC, 32'h003CA55A);
    dac_obs(16'h00FF, 16'hA55A, 8'h3C, ns, nst, bad);
    chk("R9 dac setup cycles", 32'(ns), 32'd3);
    chk("R9 dac strobe cycles", 32'(nst), 32'd2);
    chk("R9 dac 8-bit pins", 32'(bad), 32'd0);
    reg_w(RA_CTRL, 32'h0E);
    reg_w(RA_TIME, {16'd40, 8'd0, 8'd0});
    reg_w(RA_DAC, 32'h00C3B44B);
    dac_obs(16'hFFFF, 16'hB44B, 8'hC3, ns, nst, bad);
    chk("R9 dac 16-bit strobe", 32'(nst), 32'd1);
    chk("R9 dac 16-bit pins", 32'(bad), 32'd0);

    // R10 simultaneous requests
    reg_w(RA_CTRL, 32'h1C);
    reg_w(RA_TIME, {16'd20, 8'd1, 8'd1});
    adc_rdy = 1'b1;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = RA_DAC; reg_wdata = 32'h005A1234; int_trig = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = RA_STAT; int_trig = 1'b0;
    fcs = -1; fwr = -1; ov = 0;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (!adc_cs_n && fcs < 0) fcs = i;
      if (!dac_wr_n && fwr < 0) fwr = i;
      if (!adc_cs_n && !dac_wr_n) ov++;
      @(negedge clk);
    end
    adc_rdy = 1'b0;
    chk("R10 conversion ran", {31'b0, fcs >= 0}, 32'd1);
    chk("R10 conversion before dac", {31'b0, fwr > fcs}, 32'd1);
    chk("R10 no overlap", 32'(ov), 32'd0);
    reg_r(RA_RES, rd);

    // R11 lane ownership and GPIO
    reg_w(RA_CTRL, 32'h00);
    reg_w(RA_GDIR, 32'hF0F00F);
    reg_w(RA_GOUT, 32'h123456);
    #1;
    chk("R11 24 channels enable", {8'b0, pd_oe, pa_oe}, 32'hF0F00F);
    chk("R11 24 channels value", {8'b0, pd_o, pa_o}, 32'h123456);
    reg_w(RA_CTRL, 32'h04);
    #1;
    chk("R11 16 channels enable", {8'b0, pd_oe, pa_oe}, 32'hF0F000);
    reg_w(RA_CTRL, 32'h0C);
    #1;
    chk("R11 8 channels enable", {8'b0, pd_oe, pa_oe}, 32'hF00000);
    chk("R11 8 channels value", {24'b0, pd_o[15:8]}, 32'h12);
    reg_w(RA_CTRL, 32'h0D);
    #1;
    chk("R11 0 channels enable", {8'b0, pd_oe, pa_oe}, 32'h0);

    // R12 pin readback
    pa_i = 8'hA5; pd_i = 16'h1234;
    reg_r(RA_GIN, rd);
    chk("R12 pin input register", rd, 32'h1234A5);

    summary();
  end
endmodule